// File: doc/BRIEF.md
# Branch Direction and Target Predictor with Static Fallback

This block sits in an instruction fetch front end. For every branch presented at its lookup port, it predicts whether the branch is taken and where fetch should go next. It also reports how many fetch cycles the prediction costs. The prediction is ready one cycle after the lookup. A set-associative target table is indexed by the branch's fetch address. Each entry holds a tag, a target and a four-bit record of that branch's most recent outcomes. That record selects one of a shared set of two-bit saturating counters, and the counter gives the predicted direction.

When the address misses the table, a fixed rule takes over: branches that jump backwards are predicted taken and branches that jump forwards are predicted not taken. This path reports the long penalty class. Calls and returns use a small circular stack of fall-through addresses. When a branch resolves, the execution side reports the outcome on the update port. The table then trains the matching entry, or allocates a new entry for a taken branch it did not hold.

Top module: `bp_top`

## Requirements
- R1: After reset, `pr_valid` is 0, every table entry is invalid, and every pattern counter holds 1 (weakly not taken).
- R2: A lookup presented on a rising edge yields `pr_valid` = 1 from that edge. For a conditional branch (`lk_kind` 0 or 3) that hits, the direction is bit 1 of the counter selected by the entry's 4-bit history. The target is the stored target if the branch is predicted taken, and `lk_fallthru` otherwise.
- R3: A conditional hit predicted taken reports a penalty of 1, and a conditional hit predicted not taken reports 0.
- R4: A conditional lookup that misses predicts taken with target `lk_static_tgt` when `lk_backward` is 1. When `lk_backward` is 0, it predicts not taken with target `lk_fallthru`. Either way it reports penalty 6 and `pr_hit` = 0.
- R5: An update that hits does three things. It shifts `up_taken` into bit 0 of the entry's history and drops bit 3. It moves the counter selected by the old history up (taken) or down (not taken), saturating at 0 and 3. On taken, it replaces the stored target with `up_target`.
- R6: An update that misses allocates an entry when taken, with history 0001 and counters unchanged. When not taken, it changes nothing.
- R7: Allocation fills an invalid way of the set first. Otherwise it evicts the least recently used way, where an update hit or an allocation counts as a use. The set is fetch address bits [5:2], and the tag is bits [31:6].
- R8: A call (`lk_kind` 1) is predicted taken. Its target is the stored target with penalty 1 on a hit, and `lk_static_tgt` with penalty 6 on a miss. The call pushes `lk_fallthru` onto the return stack.
- R9: A return (`lk_kind` 2) is predicted taken to the address on top of the return stack, with penalty 1, and pops that address.
- R10: The return stack holds 8 addresses. A ninth push overwrites the oldest address, and the pointer wraps on both push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch address of the branch |
| lk_kind | input | 2 | 0 conditional, 1 call, 2 return, 3 conditional |
| lk_backward | input | 1 | Branch displacement is negative |
| lk_static_tgt | input | 32 | Target decoded from the instruction |
| lk_fallthru | input | 32 | Address of the next sequential instruction |
| up_valid | input | 1 | Resolution report |
| up_pc | input | 32 | Fetch address of the resolved branch |
| up_taken | input | 1 | Actual direction |
| up_target | input | 32 | Actual target |
| pr_valid | output | 1 | Prediction valid |
| pr_hit | output | 1 | Lookup hit the target table |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | 32 | Predicted next fetch address |
| pr_penalty | output | 3 | Penalty class in cycles: 0, 1 or 6 |

## Verification
Each prediction is registered, so it appears on the outputs one clock after the lookup edge. The bench drives a lookup on a falling edge and queues the expected result. A monitor then compares the outputs on the following falling edge, which is the first point where the registered result is stable. An update applies on the rising edge after it is driven. Because each driving task spends a full cycle, every later lookup sees the trained table, the counters and the stack. Expected values come from hand-traced sequences: history shifting, counter training, least-recently-used eviction and stack wrap.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        K_COND = 2'd0,
        K_CALL = 2'd1,
        K_RET  = 2'd2,
        K_ALT  = 2'd3
    } br_kind_e;

    localparam logic [2:0] PEN_NONE   = 3'd0;
    localparam logic [2:0] PEN_DYN    = 3'd1;
    localparam logic [2:0] PEN_STATIC = 3'd6;

    localparam logic [1:0] CTR_INIT = 2'b01;

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int SETS   = 16,
    parameter int WAYS   = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_tgt,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    output logic              up_hit,
    output logic [HIST_W-1:0] up_hist
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    logic              vld_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q  [SETS][WAYS];
    logic [HIST_W-1:0] hist_q [SETS][WAYS];
    logic [WAY_W-1:0]  age_q  [SETS][WAYS];

    logic [IDX_W-1:0] l_idx, u_idx;
    logic [TAG_W-1:0] l_tag, u_tag;
    logic [WAY_W-1:0] hit_way, vic_way, sel_way;
    logic             vic_found;

    assign l_idx = lk_pc[OFF_W +: IDX_W];
    assign l_tag = lk_pc[ADDR_W-1 -: TAG_W];
    assign u_idx = up_pc[OFF_W +: IDX_W];
    assign u_tag = up_pc[ADDR_W-1 -: TAG_W];

    always_comb begin
        lk_hit  = 1'b0;
        lk_tgt  = '0;
        lk_hist = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[l_idx][w] && tag_q[l_idx][w] == l_tag) begin
                lk_hit  = 1'b1;
                lk_tgt  = tgt_q[l_idx][w];
                lk_hist = hist_q[l_idx][w];
            end
        end
    end

    always_comb begin
        up_hit  = 1'b0;
        up_hist = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld_q[u_idx][w] && tag_q[u_idx][w] == u_tag) begin
                up_hit  = 1'b1;
                up_hist = hist_q[u_idx][w];
                hit_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        vic_way   = '0;
        vic_found = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vic_found && !vld_q[u_idx][w]) begin
                vic_way   = WAY_W'(w);
                vic_found = 1'b1;
            end
        end
        if (!vic_found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[u_idx][w] == WAY_W'(WAYS - 1))
                    vic_way = WAY_W'(w);
            end
        end
    end

    assign sel_way = up_hit ? hit_way : vic_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w] <= 1'b0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (up_valid && (up_hit || up_taken)) begin
            if (up_hit) begin
                hist_q[u_idx][sel_way] <= {up_hist[HIST_W-2:0], up_taken};
                if (up_taken)
                    tgt_q[u_idx][sel_way] <= up_target;
            end else begin
                vld_q[u_idx][sel_way]  <= 1'b1;
                tag_q[u_idx][sel_way]  <= u_tag;
                tgt_q[u_idx][sel_way]  <= up_target;
                hist_q[u_idx][sel_way] <= HIST_W'(1);
            end
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == sel_way)
                    age_q[u_idx][w] <= '0;
                else if (age_q[u_idx][w] < age_q[u_idx][sel_way])
                    age_q[u_idx][w] <= age_q[u_idx][w] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bp_pht.sv
module bp_pht
    import bp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_idx,
    output logic              rd_taken,
    input  logic              wr_en,
    input  logic [HIST_W-1:0] wr_idx,
    input  logic              wr_taken
);
    localparam int N_CTR = 1 << HIST_W;

    logic [1:0] ctr_q [N_CTR];

    assign rd_taken = ctr_q[rd_idx][1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CTR; i++)
                ctr_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] top
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] stk_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;

    assign top = stk_q[ptr_q - 1'b1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                stk_q[i] <= '0;
        end else if (push) begin
            stk_q[ptr_q] <= push_addr;
            ptr_q        <= ptr_q + 1'b1;
        end else if (pop) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

endmodule

// File: rtl/bp_top.sv
module bp_top
    import bp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 2,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int HIST_W    = 4,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [1:0]        lk_kind,
    input  logic              lk_backward,
    input  logic [ADDR_W-1:0] lk_static_tgt,
    input  logic [ADDR_W-1:0] lk_fallthru,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    output logic              pr_valid,
    output logic              pr_hit,
    output logic              pr_taken,
    output logic [ADDR_W-1:0] pr_target,
    output logic [2:0]        pr_penalty
);
    logic              b_hit, b_up_hit, pht_taken;
    logic [ADDR_W-1:0] b_tgt, ras_top;
    logic [HIST_W-1:0] b_hist, b_up_hist;
    br_kind_e          kind;

    logic              n_taken;
    logic [ADDR_W-1:0] n_tgt;
    logic [2:0]        n_pen;

    assign kind = br_kind_e'(lk_kind);

    bp_btb #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS), .HIST_W(HIST_W)
    ) u_btb (
        .clk(clk), .rst(rst),
        .lk_pc(lk_pc), .lk_hit(b_hit), .lk_tgt(b_tgt), .lk_hist(b_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_target(up_target), .up_hit(b_up_hit), .up_hist(b_up_hist)
    );

    bp_pht #(.HIST_W(HIST_W)) u_pht (
        .clk(clk), .rst(rst),
        .rd_idx(b_hist), .rd_taken(pht_taken),
        .wr_en(up_valid && b_up_hit), .wr_idx(b_up_hist), .wr_taken(up_taken)
    );

    bp_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk(clk), .rst(rst),
        .push(lk_valid && kind == K_CALL), .push_addr(lk_fallthru),
        .pop(lk_valid && kind == K_RET), .top(ras_top)
    );

    always_comb begin
        unique case (kind)
            K_RET: begin
                n_taken = 1'b1;
                n_tgt   = ras_top;
                n_pen   = PEN_DYN;
            end
            K_CALL: begin
                n_taken = 1'b1;
                n_tgt   = b_hit ? b_tgt : lk_static_tgt;
                n_pen   = b_hit ? PEN_DYN : PEN_STATIC;
            end
            default: begin
                if (b_hit) begin
                    n_taken = pht_taken;
                    n_tgt   = pht_taken ? b_tgt : lk_fallthru;
                    n_pen   = pht_taken ? PEN_DYN : PEN_NONE;
                end else begin
                    n_taken = lk_backward;
                    n_tgt   = lk_backward ? lk_static_tgt : lk_fallthru;
                    n_pen   = PEN_STATIC;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_valid   <= 1'b0;
            pr_hit     <= 1'b0;
            pr_taken   <= 1'b0;
            pr_target  <= '0;
            pr_penalty <= PEN_NONE;
        end else begin
            pr_valid <= lk_valid;
            if (lk_valid) begin
                pr_hit     <= b_hit;
                pr_taken   <= n_taken;
                pr_target  <= n_tgt;
                pr_penalty <= n_pen;
            end
        end
    end

endmodule

// File: rtl/bp_checker.sv
module bp_checker
    import bp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [1:0]        lk_kind,
    input logic              pr_valid,
    input logic              pr_hit,
    input logic              pr_taken,
    input logic [2:0]        pr_penalty
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pr_valid);  // R1

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> pr_valid);  // R2

    AST_HIT_NT_NO_PENALTY: assert property (@(posedge clk) disable iff (rst)
        (pr_valid && pr_hit && !pr_taken) |-> pr_penalty == PEN_NONE);  // R3

    AST_MISS_STATIC_PENALTY: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind != 2'(K_RET)) |=> (pr_hit || pr_penalty == PEN_STATIC));  // R4

    AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 2'(K_CALL)) |=> pr_taken);  // R8

    AST_RET_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_kind == 2'(K_RET)) |=> (pr_taken && pr_penalty == PEN_DYN));  // R9

endmodule

bind bp_top bp_checker #(.ADDR_W(ADDR_W)) u_bp_checker (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_kind(lk_kind),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken),
    .pr_penalty(pr_penalty)
);

// File: tb/test_bp_top.sv
module test_bp_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          lk_valid, lk_backward, up_valid, up_taken;
    logic [1:0]    lk_kind;
    logic [AW-1:0] lk_pc, lk_static_tgt, lk_fallthru, up_pc, up_target;
    logic          pr_valid, pr_hit, pr_taken;
    logic [AW-1:0] pr_target;
    logic [2:0]    pr_penalty;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic          hit;
        logic          taken;
        logic [AW-1:0] tgt;
        logic [2:0]    pen;
        string         req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_top i_bp_top (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .lk_backward(lk_backward), .lk_static_tgt(lk_static_tgt),
        .lk_fallthru(lk_fallthru), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target), .pr_valid(pr_valid),
        .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target),
        .pr_penalty(pr_penalty)
    );

    task automatic lookup(input logic [AW-1:0] pc, input logic [1:0] kind,
                          input logic back, input logic [AW-1:0] stgt,
                          input logic [AW-1:0] ft, input logic e_hit,
                          input logic e_taken, input logic [AW-1:0] e_tgt,
                          input logic [2:0] e_pen, input string req);
        exp_t e;
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; lk_kind = kind; lk_backward = back;
        lk_static_tgt = stgt; lk_fallthru = ft;
        e.hit = e_hit; e.taken = e_taken; e.tgt = e_tgt; e.pen = e_pen; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic update(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    // monitor: results appear one edge after the lookup, compared on the next falling edge
    always @(negedge clk) begin
        if (!rst && pr_valid && !done) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2: unexpected prediction, actual tgt=%h expected none", pr_target);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (pr_hit !== e.hit || pr_taken !== e.taken || pr_target !== e.tgt ||
                    pr_penalty !== e.pen) begin
                    bad++;
                    $display("FAIL %s: actual hit=%0b taken=%0b tgt=%h pen=%0d expected hit=%0b taken=%0b tgt=%h pen=%0d",
                             e.req, pr_hit, pr_taken, pr_target, pr_penalty,
                             e.hit, e.taken, e.tgt, e.pen);
                end
            end
        end
    end

    initial begin
        for (int n = 0; n < 100000; n++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; up_valid = 1'b0; lk_pc = '0; lk_kind = 2'd0;
        lk_backward = 1'b0; lk_static_tgt = '0; lk_fallthru = '0;
        up_pc = '0; up_taken = 1'b0; up_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        total++;
        if (pr_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: pr_valid actual=%0b expected=0", pr_valid);
        end

        // R1 R4: empty table, static rule
        lookup(32'h2000, 2'd0, 1'b1, 32'h1F00, 32'h2004, 0, 1, 32'h1F00, 3'd6, "R4");
        lookup(32'h2000, 2'd3, 1'b0, 32'h2100, 32'h2004, 0, 0, 32'h2004, 3'd6, "R4");

        // R7: fill set 3 with four branches, reuse the first, allocate a fifth
        for (int k = 0; k < 4; k++) update(32'(k*64 + 12), 1'b1, 32'(32'h500 + k*16));
        update(32'h0C, 1'b1, 32'h500);
        update(32'h10C, 1'b1, 32'h540);
        lookup(32'h0C, 2'd0, 1'b0, 32'h0, 32'h10, 1, 0, 32'h10, 3'd0, "R7");
        lookup(32'h4C, 2'd0, 1'b0, 32'h0, 32'h50, 0, 0, 32'h50, 3'd6, "R7");
        lookup(32'h10C, 2'd0, 1'b0, 32'h0, 32'h110, 1, 1, 32'h540, 3'd1, "R2");
        lookup(32'h8C, 2'd0, 1'b0, 32'h0, 32'h90, 1, 1, 32'h520, 3'd1, "R3");

        // R5 R6: history training on one branch
        for (int k = 0; k < 4; k++) update(32'h100, 1'b1, 32'h80);
        lookup(32'h100, 2'd0, 1'b1, 32'h0, 32'h104, 1, 0, 32'h104, 3'd0, "R5");
        update(32'h100, 1'b1, 32'h90);
        lookup(32'h100, 2'd0, 1'b0, 32'h0, 32'h104, 1, 1, 32'h90, 3'd1, "R5");
        update(32'h100, 1'b0, 32'h0);
        lookup(32'h100, 2'd0, 1'b1, 32'h0, 32'h104, 1, 0, 32'h104, 3'd0, "R5");
        update(32'h3000, 1'b0, 32'h3800);
        lookup(32'h3000, 2'd0, 1'b1, 32'h2F00, 32'h3004, 0, 1, 32'h2F00, 3'd6, "R6");

        // R8 R9: calls and returns
        lookup(32'h4000, 2'd1, 1'b0, 32'h4800, 32'h4004, 0, 1, 32'h4800, 3'd6, "R8");
        lookup(32'h0C, 2'd1, 1'b0, 32'h900, 32'h10, 1, 1, 32'h500, 3'd1, "R8");
        lookup(32'h9000, 2'd2, 1'b0, 32'h0, 32'h9004, 0, 1, 32'h10, 3'd1, "R9");
        lookup(32'h9000, 2'd2, 1'b0, 32'h0, 32'h9004, 0, 1, 32'h4004, 3'd1, "R9");

        // R10: nine pushes wrap over the oldest
        for (int k = 0; k < 9; k++)
            lookup(32'(32'h6000 + k*4), 2'd1, 1'b0, 32'h6800, 32'(32'h7000 + k*16),
                   0, 1, 32'h6800, 3'd6, "R8");
        for (int k = 8; k >= 1; k--)
            lookup(32'h9000, 2'd2, 1'b0, 32'h0, 32'h9004, 0, 1, 32'(32'h7000 + k*16), 3'd1, "R10");
        lookup(32'h9000, 2'd2, 1'b0, 32'h0, 32'h9004, 0, 1, 32'h7080, 3'd1, "R10");

        repeat (3) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2: pending actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule